// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects up to eight interrupt request lines and signals the processor when an unmasked request outranks every level already being serviced. The priority order is fixed. When the processor returns a one-cycle acknowledge, the block answers with an 8-bit vector. It also records the winning level as in service until an end-of-interrupt command arrives. In automatic end-of-interrupt mode, nothing is recorded as in service.

A byte-wide register port with a single address bit configures the block. Address 0 takes commands and gives back either the request or the in-service register. Address 1 holds the mask. An initialization command opens a sequence of data writes whose meaning depends on their position: vector base, then cascade word, then an optional mode word. Outside that sequence, a data write loads the mask. The cascade word is kept and driven on its own output for the cascade logic around the block.

Top module: `pic_core`

## Requirements
- R1: After reset, `int_o` and `vec_vld_o` are low, the mask reads 0xFF (all lines disabled), and the request and in-service registers are empty.
- R2: A command write with bit 4 set starts initialization and clears the mask, request and in-service registers, and selects request readback. The next data writes are taken as the vector base, then the cascade word (driven on `cascade_o`), then, only if bit 0 of the start command was set, the mode word. The first data write is never taken as a mask.
- R3: The vector is the vector base with its low three bits replaced by the acknowledged level, so base 0x20 and level 3 give 0x23.
- R4: Outside initialization, a data write loads the mask, and a data read returns it. A 1 in mask bit n keeps line n from raising `int_o`, although the request is still recorded.
- R5: Level 0 has the highest priority. `int_o` is high only while the highest-priority unmasked request is above every in-service level.
- R6: On acknowledge of a real request, `vec_vld_o` is high with the vector in the next cycle, the request bit is cleared and the in-service bit of that level is set.
- R7: Mode word bit 1 set (0x03) selects automatic end-of-interrupt: acknowledge leaves the in-service register unchanged. 0x01 selects normal operation.
- R8: Command 0x60+n clears in-service bit n and no other bit.
- R9: Command 0x20 clears only the highest-priority in-service bit.
- R10: Command 0x0A selects the request register and 0x0B selects the in-service register for command-address reads.
- R11: An acknowledge with no eligible request returns the base plus level 7 and leaves the in-service register unchanged. This holds even when line 7 is masked.
- R12: A request bit is set on a rising edge of its line and is cleared when the line falls before acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 1 | 0 = command location, 1 = data location |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the location on `addr_i` |
| irq_i | input | 8 | Interrupt request lines, bit 0 highest priority |
| int_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | One-cycle interrupt acknowledge |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |
| cascade_o | output | 8 | Cascade word stored during initialization |

## Verification
Register writes, request edges and acknowledges all take effect at the first rising edge after they are applied. The bench drives each stimulus on a falling edge and samples one falling edge later, after exactly one register stage. `int_o` and `rdata_o` are combinational from registered state, so they are read at that same falling edge. `vec_o` and `vec_vld_o` are registered on the acknowledge edge and are checked in the half cycle after it, while `vec_vld_o` is still high.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NLINES = 8;
  localparam int LVLW   = $clog2(NLINES);
  localparam int SELW   = LVLW + 1;             // one extra code for "none"
  localparam logic [SELW-1:0] NONE = SELW'(NLINES);

  typedef enum logic [1:0] {
    CFG_RUN, CFG_BASE, CFG_CASC, CFG_MODE
  } cfg_state_e;

  // Lowest set index, or NONE when the vector is empty
  function automatic logic [SELW-1:0] first_set(input logic [NLINES-1:0] v);
    logic [SELW-1:0] r;
    r = NONE;
    for (int i = NLINES - 1; i >= 0; i--)
      if (v[i]) r = SELW'(i);
    return r;
  endfunction

  function automatic logic [NLINES-1:0] lvl_bit(input logic [LVLW-1:0] lvl);
    return NLINES'(1) << lvl;
  endfunction

  function automatic logic [7:0] make_vector(input logic [7:0] base,
                                             input logic [LVLW-1:0] lvl);
    return {base[7:LVLW], lvl};
  endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [NLINES-1:0] mask_q,
  output logic [7:0]        base_q,
  output logic [7:0]        casc_q,
  output logic              aeoi_q,
  output logic              rd_isr_q,
  output logic              init_start,
  output logic              eoi_ns,
  output logic              eoi_sp,
  output logic [LVLW-1:0]   eoi_lvl
);
  cfg_state_e state_q;
  logic       want_mode_q;
  logic       cmd_wr, dat_wr, ocw3_wr;

  assign cmd_wr     = wr_i && !addr_i;
  assign dat_wr     = wr_i && addr_i;
  assign init_start = cmd_wr && wdata_i[4];
  assign ocw3_wr    = cmd_wr && !wdata_i[4] && wdata_i[3];
  assign eoi_ns     = cmd_wr && !wdata_i[4] && !wdata_i[3] && (wdata_i[7:5] == 3'b001);
  assign eoi_sp     = cmd_wr && !wdata_i[4] && !wdata_i[3] && (wdata_i[7:5] == 3'b011);
  assign eoi_lvl    = wdata_i[LVLW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= CFG_RUN;
      want_mode_q <= 1'b0;
      mask_q      <= '1;
      base_q      <= '0;
      casc_q      <= '0;
      aeoi_q      <= 1'b0;
      rd_isr_q    <= 1'b0;
    end else if (init_start) begin
      state_q     <= CFG_BASE;
      want_mode_q <= wdata_i[0];
      mask_q      <= '0;
      aeoi_q      <= 1'b0;
      rd_isr_q    <= 1'b0;
    end else begin
      if (ocw3_wr && wdata_i[1]) rd_isr_q <= wdata_i[0];
      if (dat_wr) begin
        unique case (state_q)
          CFG_BASE: begin
            base_q  <= wdata_i;
            state_q <= CFG_CASC;
          end
          CFG_CASC: begin
            casc_q  <= wdata_i;
            state_q <= want_mode_q ? CFG_MODE : CFG_RUN;
          end
          CFG_MODE: begin
            aeoi_q  <= wdata_i[1];
            state_q <= CFG_RUN;
          end
          default: mask_q <= wdata_i;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_i,
  input  logic              clr_all,
  input  logic [NLINES-1:0] ack_clr,
  output logic [NLINES-1:0] irr_q,
  output logic [NLINES-1:0] line_q
);
  logic [NLINES-1:0] rise;
  assign rise = irq_i & ~line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      line_q <= '0;
    end else begin
      line_q <= irq_i;
      if (clr_all) irr_q <= '0;
      else         irr_q <= (irr_q | rise) & irq_i & ~ack_clr;
    end
  end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
(
  input  logic [NLINES-1:0] irr,
  input  logic [NLINES-1:0] mask,
  input  logic [NLINES-1:0] isr,
  output logic [SELW-1:0]   win_lvl,
  output logic [SELW-1:0]   isr_top,
  output logic              req
);
  assign win_lvl = first_set(irr & ~mask);
  assign isr_top = first_set(isr);
  assign req     = (win_lvl != NONE) && (win_lvl < isr_top);
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [7:0]  irq_i,
  output logic        int_o,
  input  logic        ack_i,
  output logic [7:0]  vec_o,
  output logic        vec_vld_o,
  output logic [7:0]  cascade_o
);
  logic [NLINES-1:0] mask_q, irr_q, line_q, isr_q;
  logic [NLINES-1:0] ack_clr, isr_set, isr_clr;
  logic [7:0]        base_q;
  logic              aeoi_q, rd_isr_q;
  logic              init_start, eoi_ns, eoi_sp;
  logic [LVLW-1:0]   eoi_lvl;
  logic [SELW-1:0]   win_lvl, isr_top;
  logic              req;
  logic              ack_hit, ack_spur;
  logic [LVLW-1:0]   ack_lvl;

  pic_cfg_regs u_cfg (
    .clk, .rst_n, .addr_i, .wr_i, .wdata_i,
    .mask_q, .base_q, .casc_q(cascade_o), .aeoi_q, .rd_isr_q,
    .init_start, .eoi_ns, .eoi_sp, .eoi_lvl
  );

  pic_req_latch u_req (
    .clk, .rst_n, .irq_i, .clr_all(init_start), .ack_clr, .irr_q, .line_q
  );

  pic_resolver u_res (
    .irr(irr_q), .mask(mask_q), .isr(isr_q), .win_lvl, .isr_top, .req
  );

  // Named acknowledge events
  assign ack_hit  = ack_i && req;
  assign ack_spur = ack_i && !req;
  assign ack_lvl  = ack_hit ? win_lvl[LVLW-1:0] : LVLW'(NLINES - 1);
  assign ack_clr  = ack_hit ? lvl_bit(ack_lvl) : '0;
  assign isr_set  = (ack_hit && !aeoi_q) ? lvl_bit(ack_lvl) : '0;

  always_comb begin
    isr_clr = '0;
    if (eoi_sp)                          isr_clr = lvl_bit(eoi_lvl);
    else if (eoi_ns && isr_top != NONE)  isr_clr = lvl_bit(isr_top[LVLW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q     <= '0;
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
    end else begin
      if (init_start) isr_q <= '0;
      else            isr_q <= (isr_q & ~isr_clr) | isr_set;
      vec_vld_o <= ack_i;
      if (ack_i) vec_o <= make_vector(base_q, ack_lvl);
    end
  end

  assign int_o   = req;
  assign rdata_o = addr_i ? mask_q : (rd_isr_q ? isr_q : irr_q);
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
  import pic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_i,
  input logic              int_o,
  input logic              vec_vld_o,
  input logic [7:0]        vec_o,
  input logic [NLINES-1:0] irr_q,
  input logic [NLINES-1:0] isr_q,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] line_q,
  input logic [7:0]        base_q,
  input logic              aeoi_q,
  input logic              ack_hit,
  input logic              ack_spur,
  input logic              init_start
);
  assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (isr_q == '0) && (irr_q == '0) && (mask_q == '0));

  assert_vec_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> vec_o[7:LVLW] == $past(base_q[7:LVLW]));

  assert_int_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> |(irr_q & ~mask_q));

  assert_ack_in_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !aeoi_q && !wr_i) |=> isr_q[vec_o[LVLW-1:0]] && vec_vld_o);

  assert_auto_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && aeoi_q && !wr_i) |=> $stable(isr_q));

  assert_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_spur && !wr_i) |=> (vec_o[LVLW-1:0] == LVLW'(NLINES - 1)) && $stable(isr_q));

  assert_req_follows_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_q & ~line_q) == '0);
endmodule

bind pic_core pic_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .int_o(int_o),
  .vec_vld_o(vec_vld_o), .vec_o(vec_o), .irr_q(irr_q), .isr_q(isr_q),
  .mask_q(mask_q), .line_q(line_q), .base_q(base_q), .aeoi_q(aeoi_q),
  .ack_hit(ack_hit), .ack_spur(ack_spur), .init_start(init_start)
);

// File: tb/pic_core_tb_top.sv
module pic_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] irq_i = '0;
  logic       int_o;
  logic       ack_i = 1'b0;
  logic [7:0] vec_o;
  logic       vec_vld_o;
  logic [7:0] cascade_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  pic_core dut_i (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr_i = a; #1;
    chk(tag, rdata_o, exp);
  endtask

  task automatic drive_irq(input logic [7:0] v);
    @(negedge clk); irq_i = v;
    @(negedge clk);
  endtask

  task automatic ack_chk(input logic [7:0] exp, input string tag);
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
    chk({tag, " valid"}, {7'd0, vec_vld_o}, 8'd1);
    chk({tag, " vector"}, vec_o, exp);
  endtask

  task automatic t_reset;
    rd_chk(1'b1, 8'hFF, "R1 mask after reset");
    rd_chk(1'b0, 8'h00, "R1 request reg after reset");
    chk("R1 int after reset", {7'd0, int_o}, 8'd0);
    chk("R1 vec_vld after reset", {7'd0, vec_vld_o}, 8'd0);
  endtask

  task automatic t_init_master;
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    chk("R2 cascade word", cascade_o, 8'h04);
    rd_chk(1'b1, 8'h00, "R2 mask cleared by init");
    rd_chk(1'b0, 8'h00, "R2 request readback default");
  endtask

  task automatic t_basic_ack;
    drive_irq(8'h08);
    chk("R12 int after rising edge", {7'd0, int_o}, 8'd1);
    rd_chk(1'b0, 8'h08, "R10 R12 request reg shows line 3");
    ack_chk(8'h23, "R3 R6 level 3");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h08, "R6 R10 in-service bit 3");
    wr(1'b0, 8'h0A);
    rd_chk(1'b0, 8'h00, "R6 request cleared on ack");
    wr(1'b0, 8'h0B);
  endtask

  task automatic t_priority_eoi;
    drive_irq(8'h28);                     // line 5 rises, line 3 held
    chk("R5 lower level blocked by in-service 3", {7'd0, int_o}, 8'd0);
    drive_irq(8'h2A);                     // line 1 rises
    chk("R5 higher level raises int", {7'd0, int_o}, 8'd1);
    ack_chk(8'h21, "R5 level 1 wins");
    rd_chk(1'b0, 8'h0A, "R6 in-service 1 and 3");
    wr(1'b0, 8'h63);
    rd_chk(1'b0, 8'h02, "R8 specific EOI clears only bit 3");
    chk("R5 level 5 still below 1", {7'd0, int_o}, 8'd0);
    wr(1'b0, 8'h20);
    rd_chk(1'b0, 8'h00, "R9 non-specific clears bit 1");
    chk("R5 level 5 now eligible", {7'd0, int_o}, 8'd1);
    ack_chk(8'h25, "R5 level 5");
    drive_irq(8'h2E);                     // line 2 rises
    ack_chk(8'h22, "R5 level 2 preempts");
    rd_chk(1'b0, 8'h24, "R6 in-service 2 and 5");
    wr(1'b0, 8'h20);
    rd_chk(1'b0, 8'h20, "R9 non-specific clears highest only");
    wr(1'b0, 8'h65);
    rd_chk(1'b0, 8'h00, "R8 specific EOI level 5");
    drive_irq(8'h00);
  endtask

  task automatic t_mask;
    wr(1'b1, 8'h04);
    rd_chk(1'b1, 8'h04, "R4 mask readback");
    wr(1'b0, 8'h0A);
    drive_irq(8'h04);
    chk("R4 masked line keeps int low", {7'd0, int_o}, 8'd0);
    rd_chk(1'b0, 8'h04, "R4 masked request recorded");
    wr(1'b1, 8'h00);
    chk("R4 unmask raises int", {7'd0, int_o}, 8'd1);
    ack_chk(8'h22, "R4 level 2 after unmask");
    wr(1'b0, 8'h62);
    drive_irq(8'h00);
  endtask

  task automatic t_spurious;
    drive_irq(8'h10);
    chk("R12 line 4 raises int", {7'd0, int_o}, 8'd1);
    drive_irq(8'h00);
    chk("R12 int drops with line", {7'd0, int_o}, 8'd0);
    rd_chk(1'b0, 8'h00, "R12 request cleared on fall");
    wr(1'b1, 8'h80);
    ack_chk(8'h27, "R11 spurious vector with line 7 masked");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h00, "R11 in-service unchanged");
  endtask

  task automatic t_auto_eoi;
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h02); wr(1'b1, 8'h03);
    chk("R2 slave cascade id", cascade_o, 8'h02);
    rd_chk(1'b1, 8'h00, "R2 first data word not a mask");
    drive_irq(8'h40);
    ack_chk(8'h46, "R3 R7 new base level 6");
    wr(1'b0, 8'h0B);
    rd_chk(1'b0, 8'h00, "R7 automatic EOI leaves in-service clear");
    wr(1'b0, 8'h0A);
    rd_chk(1'b0, 8'h00, "R7 request cleared");
    drive_irq(8'h00);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_init_master;
    t_basic_ack;
    t_priority_eoi;
    t_mask;
    t_spurious;
    t_auto_eoi;
    done = 1'b1;
    summary;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary;
      $finish;
    end
  end
endmodule